// File: doc/BRIEF.md
# Next-PC Fetch Address Unit

This block keeps the program counter of a small single-cycle processor and works out, every clock, where the next instruction is fetched from. It takes the instruction currently being executed and the control signals decoded from it, and it drives the PC register straight onto the instruction memory address. Fetching is identical for every instruction. Only the choice of next address differs, and there are three candidates.

The first candidate is the sequential address, four bytes ahead. The second is a PC-relative branch target. The branch offset is the low 16 instruction bits, sign-extended and scaled by four, and it is added to the sequential address. The third is a region-relative jump target. It keeps the top four PC bits and fills the rest with the 26-bit target field followed by two zero bits. A branch is followed only when the decoder requests it and the ALU reports equal operands. A jump request overrides everything except reset.

Top module: `fetch_pc_unit`

## Requirements
- R1: With `jump_req`=0 and not (`branch_req`=1 and `alu_zero`=1), the PC after a rising edge is the previous PC + 4, modulo 2^32.
- R2: With `jump_req`=0, `branch_req`=1 and `alu_zero`=1, the next PC is PC + 4 + (sign-extended `instr[15:0]` shifted left by 2), modulo 2^32. `instr[31:16]` has no effect on this target.
- R3: A branch request with `alu_zero`=0, or `alu_zero`=1 without a branch request, gives PC + 4.
- R4: With `jump_req`=1 the next PC is {PC[31:28], `instr[25:0]`, 2'b00}.
- R5: When `jump_req`, `branch_req` and `alu_zero` are all 1, the jump target of R4 is taken.
- R6: `rst`=1 at a rising edge loads the PC with 0, whatever the other inputs are. Reset is synchronous and active high.
- R7: After reset, `pc[1:0]` is always 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC changes on the rising edge only |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word currently executing |
| branch_req | input | 1 | Decoder asks for a conditional branch |
| alu_zero | input | 1 | ALU equality flag |
| jump_req | input | 1 | Decoder asks for a jump |
| pc | output | 32 | Registered program counter, used as the fetch address |

## Verification
On every cycle the assertions compare the new PC with the previous PC and the previous inputs for each next-address case: sequential, taken branch, not-taken branch, jump, and jump over branch. They also check the reset load and the word alignment. Only the bench scenarios show that the arithmetic wraps at 2^32 and that a jump keeps upper PC bits that are non-zero. The bench reaches such bits through a large backward branch from address 0. The scenarios also show that the opcode bits above the immediate leave the branch target alone, and that reset in the middle of a run overrides an active jump.

// File: rtl/fpu_pkg.sv
package fpu_pkg;
  typedef enum logic [1:0] {
    NPC_SEQ    = 2'd0,
    NPC_BRANCH = 2'd1,
    NPC_JUMP   = 2'd2
  } npc_src_e;

  // Jump wins over a taken branch; otherwise fall through.
  function automatic npc_src_e pick_src(input logic jump, input logic br, input logic zero);
    if (jump)             return NPC_JUMP;
    else if (br && zero)  return NPC_BRANCH;
    else                  return NPC_SEQ;
  endfunction
endpackage

// File: rtl/fpu_select.sv
module fpu_select
  import fpu_pkg::*;
(
  input  logic     jump_req,
  input  logic     branch_req,
  input  logic     alu_zero,
  output npc_src_e src
);
  always_comb src = pick_src(jump_req, branch_req, alu_zero);
endmodule

// File: rtl/fpu_target_gen.sv
module fpu_target_gen #(
  parameter int AW           = 32,
  parameter int IMM_W        = 16,
  parameter int TGT_W        = 26,
  parameter int STEP         = 4,
  parameter bit SHARE_ADDER  = 1'b1
) (
  input  logic [AW-1:0]    pc_cur,
  input  logic [IMM_W-1:0] imm,
  input  logic [TGT_W-1:0] tgt,
  output logic [AW-1:0]    seq_pc,
  output logic [AW-1:0]    br_pc,
  output logic [AW-1:0]    jmp_pc
);
  localparam int SHIFT = $clog2(STEP);
  localparam int EXT_W = AW - IMM_W - SHIFT;
  localparam int HI_W  = AW - TGT_W - SHIFT;

  logic [AW-1:0] offset;

  always_comb begin
    offset = {{EXT_W{imm[IMM_W-1]}}, imm, {SHIFT{1'b0}}};
    seq_pc = pc_cur + AW'(STEP);
    jmp_pc = {pc_cur[AW-1 -: HI_W], tgt, {SHIFT{1'b0}}};
  end

  generate
    if (SHARE_ADDER) begin : g_chain
      // Branch target rides on the sequential sum: one adder after another.
      always_comb br_pc = seq_pc + offset;
    end else begin : g_parallel
      // Constant folded into the offset: two adders side by side.
      always_comb br_pc = pc_cur + (offset + AW'(STEP));
    end
  endgenerate
endmodule

// File: rtl/fpu_pc_reg.sv
module fpu_pc_reg #(
  parameter int AW = 32,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RESET_PC;
    else     q <= d;
  end
endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
  import fpu_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IW    = 32,
  parameter int IMM_W = 16,
  parameter int TGT_W = 26,
  parameter int STEP  = 4,
  parameter bit SHARE_ADDER = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] instr,
  input  logic          branch_req,
  input  logic          alu_zero,
  input  logic          jump_req,
  output logic [AW-1:0] pc
);
  npc_src_e      src;
  logic [AW-1:0] seq_pc, br_pc, jmp_pc, nxt_pc;
  logic          unused_opcode;

  assign unused_opcode = ^instr[IW-1:TGT_W];

  fpu_select u_sel (
    .jump_req   (jump_req),
    .branch_req (branch_req),
    .alu_zero   (alu_zero),
    .src        (src)
  );

  fpu_target_gen #(
    .AW(AW), .IMM_W(IMM_W), .TGT_W(TGT_W), .STEP(STEP), .SHARE_ADDER(SHARE_ADDER)
  ) u_tgt (
    .pc_cur (pc),
    .imm    (instr[IMM_W-1:0]),
    .tgt    (instr[TGT_W-1:0]),
    .seq_pc (seq_pc),
    .br_pc  (br_pc),
    .jmp_pc (jmp_pc)
  );

  always_comb begin
    unique case (src)
      NPC_BRANCH: nxt_pc = br_pc;
      NPC_JUMP:   nxt_pc = jmp_pc;
      default:    nxt_pc = seq_pc;
    endcase
  end

  fpu_pc_reg #(.AW(AW)) u_pc (
    .clk (clk),
    .rst (rst),
    .d   (nxt_pc),
    .q   (pc)
  );
endmodule

// File: rtl/fpu_chk.sv
module fpu_chk #(
  parameter int AW = 32,
  parameter int IW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [IW-1:0] instr,
  input logic          branch_req,
  input logic          alu_zero,
  input logic          jump_req,
  input logic [AW-1:0] pc
);
  AST_RESET_LOAD: assert property (@(posedge clk) rst |=> pc == '0); // R6
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (!jump_req && !(branch_req && alu_zero)) |=> pc == $past(pc) + 32'd4); // R1
  AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!jump_req && branch_req && alu_zero) |=>
      pc == $past(pc) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}); // R2
  AST_BRANCH_SKIP: assert property (@(posedge clk) disable iff (rst)
    (!jump_req && (branch_req != alu_zero)) |=> pc == $past(pc) + 32'd4); // R3
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    jump_req |=> pc == {$past(pc[31:28]), $past(instr[25:0]), 2'b00}); // R4
  AST_JUMP_OVER_BRANCH: assert property (@(posedge clk) disable iff (rst)
    (jump_req && branch_req && alu_zero) |=> pc[27:0] == {$past(instr[25:0]), 2'b00}); // R5
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00); // R7
endmodule

bind fetch_pc_unit fpu_chk #(.AW(AW), .IW(IW)) u_fpu_chk (
  .clk(clk), .rst(rst), .instr(instr), .branch_req(branch_req),
  .alu_zero(alu_zero), .jump_req(jump_req), .pc(pc)
);

// File: tb/test_fetch_pc_unit.sv
module test_fetch_pc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic        branch_req = 1'b0;
  logic        alu_zero = 1'b0;
  logic        jump_req = 1'b0;
  logic [31:0] pc;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [31:0] model_pc = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  fetch_pc_unit i_fetch_pc_unit (
    .clk(clk), .rst(rst), .instr(instr), .branch_req(branch_req),
    .alu_zero(alu_zero), .jump_req(jump_req), .pc(pc)
  );

  // Driver: apply one cycle of stimulus, predict the PC after the edge.
  task automatic step(input logic r, input logic [31:0] ins, input logic br,
                      input logic z, input logic j, input string tag);
    logic [31:0] nxt;
    @(negedge clk);
    rst = r; instr = ins; branch_req = br; alu_zero = z; jump_req = j;
    if (r)           nxt = 32'h0;
    else if (j)      nxt = {model_pc[31:28], ins[25:0], 2'b00};
    else if (br & z) nxt = model_pc + 32'd4 + {{14{ins[15]}}, ins[15:0], 2'b00};
    else             nxt = model_pc + 32'd4;
    @(posedge clk);
    model_pc = nxt;
    exp_q.push_back(nxt);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare away from the active edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (pc !== e) begin
        failures++;
        $display("FAIL %s pc=%h expected=%h", t, pc, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      failures++;
      $display("FAIL watchdog cycles=%0d expected<=5000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(1, 32'h0, 0, 0, 0, "R6 reset");             // 0
    step(0, 32'h0, 0, 0, 0, "R1 seq");               // 4
    step(0, 32'hDEAD_0000, 0, 0, 0, "R1 seq");       // 8
    step(0, 32'h1000_0003, 1, 1, 0, "R2 fwd");       // 24
    step(0, 32'h0000_FFFE, 1, 1, 0, "R2 back");      // 20
    step(0, 32'hFFFF_0003, 1, 1, 0, "R2 hi bits");   // 36
    step(0, 32'h0000_0100, 1, 0, 0, "R3 no zero");   // 40
    step(0, 32'h0000_0100, 0, 1, 0, "R3 no req");    // 44
    step(0, 32'hFC00_0100, 0, 0, 1, "R4 jump");      // 0x400
    step(0, 32'h0000_002A, 1, 1, 1, "R5 priority");  // 0xA8
    step(1, 32'h0000_0000, 0, 0, 0, "R6 reset");     // 0
    step(0, 32'h0000_8000, 1, 1, 0, "R2 wrap");      // 0xFFFE0004
    step(0, 32'h0000_0123, 0, 0, 1, "R4 upper");     // 0xF000048C
    step(0, 32'h0000_0000, 0, 0, 0, "R1 seq");       // 0xF0000490
    step(0, 32'h0000_7FFF, 0, 1, 0, "R3 no req");
    step(1, 32'h03FF_FFFF, 1, 1, 1, "R6 over jump"); // 0
    step(0, 32'h03FF_FFFF, 0, 0, 1, "R4 max tgt");   // 0x0FFFFFFC
    step(0, 32'h0, 0, 0, 0, "R7 align");
    @(negedge clk);
    @(negedge clk);
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard left=%0d expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule